// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out the vector-length setup instruction of a scalar core that has been extended with vector operation. It holds three pieces of vector state: the active vector length (VL), the maximum vector length (MVL) and a vertical-first mode flag. Each cycle that `issue_valid` is high, the block decodes the 32-bit instruction word and works out a new MVL and a new VL. The new VL comes from one of four sources: the loop count register, a general register value, a biased immediate, or the VL already held. The block then clamps VL so that it never exceeds MVL.

Writeback, zero-flag and illegal-instruction outputs are combinational and are valid in the same cycle as the strobe. The held state takes the new values at the next rising clock edge. The surrounding pipeline supplies the register read value and the loop count, and it consumes the writeback request.

Fields use big-endian bit numbering. Bit k of the instruction is `instr[31-k]`.

Top module: `vl_config_unit`

## Requirements
- R1: After reset, `vl_out`, `mvl_out` and `vfirst_out` are all 0.
- R2: An issued instruction is legal only when `instr[31:26]` equals the parameter `PRIMARY_OP` (default 22) and `instr[5:1]` equals 5'b11110. An illegal issue raises `illegal` in the same cycle, leaves VL, MVL and the vertical-first flag unchanged, and asserts neither `wb_en` nor `zero_valid`.
- R3: When the MVL-enable bit `instr[8]` is 1, MVL becomes the 6-bit immediate `instr[15:10]` plus 1. When that bit is 0, MVL is held.
- R4: When the VL-enable bit `instr[7]` is 1, the VL source is chosen by priority. The loop count input comes first if the count-select bit `instr[9]` is 1. Otherwise `gpr_value` is used if RA (`instr[20:16]`) is nonzero. Otherwise the immediate plus 1 is used. When `instr[7]` is 0, the held VL is the source.
- R5: A source value above 127 is saturated to 127. The new VL is then the smaller of the source and the new MVL, so VL never exceeds MVL.
- R6: On a legal issue with RT (`instr[25:21]`) nonzero, `wb_en` is 1, `wb_addr` equals RT and `wb_data` equals the new VL zero-extended, all in the issue cycle. With RT zero, `wb_en` is 0.
- R7: Every legal issue writes `instr[6]` into the vertical-first flag.
- R8: On a legal issue with the record bit `instr[0]` set, `zero_valid` is 1 and `zero_flag` is 1 exactly when the new VL is 0. With the record bit clear, both are 0.
- R9: Without `issue_valid`, the state holds and `wb_en`, `zero_valid` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| gpr_value | input | 64 | Value read from the register named by RA |
| count_value | input | 64 | Loop count register value |
| vl_out | output | 7 | Held vector length |
| mvl_out | output | 7 | Held maximum vector length |
| vfirst_out | output | 1 | Held vertical-first flag |
| wb_en | output | 1 | Destination register write request |
| wb_addr | output | 5 | Destination register index |
| wb_data | output | 64 | New VL, zero-extended |
| zero_valid | output | 1 | Zero flag is meaningful |
| zero_flag | output | 1 | New VL equals zero |
| illegal | output | 1 | Issued word does not decode |

## Verification
The bench targets the priority corners of source selection.

- Count-select set together with a nonzero RA must take the count. A design that reversed the priority would return the register value instead.
- RA equal to zero must fall through to the immediate plus one. Dropping the bias would give a length one short.
- Values above 127 must saturate. Truncating instead would wrap to small lengths.
- Clamping must use the MVL written by the same instruction, not the old MVL. The bench shrinks MVL below a held VL to expose this.
- Starting from MVL of zero, the bench drives VL to zero so the zero flag fires.
- Illegal words and idle cycles must leave the state untouched.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  // Instruction layout, MSB first (big-endian bit k is instr[31-k]).
  typedef struct packed {
    logic [5:0] po;     // primary opcode
    logic [4:0] rt;     // destination register
    logic [4:0] ra;     // source register
    logic [5:0] imm;    // length immediate, biased by one
    logic       cnt_sel;
    logic       set_mvl;
    logic       set_vl;
    logic       vfirst;
    logic [4:0] xo;     // extended opcode
    logic       rec;    // record bit
  } vlc_fields_t;

  localparam logic [4:0] VLC_XO = 5'b11110;
endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
  import vlc_pkg::*;
#(
  parameter logic [5:0] PRIMARY_OP = 6'd22
) (
  input  logic [31:0] instr,
  output vlc_fields_t fields,
  output logic        legal
);
  always_comb begin
    fields = vlc_fields_t'(instr);
    legal  = (fields.po == PRIMARY_OP) && (fields.xo == VLC_XO);
  end
endmodule

// File: rtl/vlc_sat.sv
module vlc_sat #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 7
) (
  input  logic [DATA_W-1:0] value,
  output logic [LEN_W-1:0]  len
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  generate
    if (DATA_W > LEN_W) begin : g_sat
      always_comb len = (|value[DATA_W-1:LEN_W]) ? LEN_MAX : value[LEN_W-1:0];
    end else begin : g_ext
      always_comb len = LEN_W'(value);
    end
  endgenerate
endmodule

// File: rtl/vlc_len_calc.sv
module vlc_len_calc #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 7
) (
  input  logic [4:0]        ra,
  input  logic [5:0]        imm,
  input  logic              cnt_sel,
  input  logic              set_mvl,
  input  logic              set_vl,
  input  logic [DATA_W-1:0] gpr_value,
  input  logic [DATA_W-1:0] count_value,
  input  logic [LEN_W-1:0]  vl_q,
  input  logic [LEN_W-1:0]  mvl_q,
  output logic [LEN_W-1:0]  vl_n,
  output logic [LEN_W-1:0]  mvl_n
);
  localparam int NSRC = 2;

  logic [DATA_W-1:0] wide_src [NSRC];
  logic [LEN_W-1:0]  sat_src  [NSRC];
  logic [LEN_W-1:0]  biased_imm;
  logic [LEN_W-1:0]  vl_src;

  assign wide_src[0] = count_value;
  assign wide_src[1] = gpr_value;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      vlc_sat #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_sat (
        .value (wide_src[i]),
        .len   (sat_src[i])
      );
    end
  endgenerate

  always_comb begin
    biased_imm = LEN_W'(imm) + LEN_W'(1);
    mvl_n      = set_mvl ? biased_imm : mvl_q;
    if (!set_vl)        vl_src = vl_q;
    else if (cnt_sel)   vl_src = sat_src[0];
    else if (ra != '0)  vl_src = sat_src[1];
    else                vl_src = biased_imm;
    vl_n = (vl_src < mvl_n) ? vl_src : mvl_n;
  end

  // R5: the computed length never exceeds the computed maximum
  always_comb begin
    a_r5_clamped: assert (vl_n <= mvl_n);
  end
endmodule

// File: rtl/vlc_state_reg.sv
module vlc_state_reg #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [LEN_W-1:0] vl_n,
  input  logic [LEN_W-1:0] mvl_n,
  input  logic             vf_n,
  output logic [LEN_W-1:0] vl_q,
  output logic [LEN_W-1:0] mvl_q,
  output logic             vf_q
);
  logic [LEN_W-1:0] vl_d, mvl_d;
  logic             vf_d;

  always_comb begin
    vl_d  = vl_q;
    mvl_d = mvl_q;
    vf_d  = vf_q;
    if (upd_en) begin
      vl_d  = vl_n;
      mvl_d = mvl_n;
      vf_d  = vf_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q  <= '0;
      mvl_q <= '0;
      vf_q  <= 1'b0;
    end else begin
      vl_q  <= vl_d;
      mvl_q <= mvl_d;
      vf_q  <= vf_d;
    end
  end

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(vl_q) && $stable(mvl_q) && $stable(vf_q));
endmodule

// File: rtl/vl_config_unit.sv
module vl_config_unit
  import vlc_pkg::*;
#(
  parameter int         DATA_W     = 64,
  parameter int         LEN_W      = 7,
  parameter logic [5:0] PRIMARY_OP = 6'd22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] gpr_value,
  input  logic [DATA_W-1:0] count_value,
  output logic [LEN_W-1:0]  vl_out,
  output logic [LEN_W-1:0]  mvl_out,
  output logic              vfirst_out,
  output logic              wb_en,
  output logic [4:0]        wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              zero_valid,
  output logic              zero_flag,
  output logic              illegal
);
  vlc_fields_t      f;
  logic             legal;
  logic             exec;
  logic [LEN_W-1:0] vl_n, mvl_n;

  vlc_decode #(.PRIMARY_OP(PRIMARY_OP)) u_dec (
    .instr  (instr),
    .fields (f),
    .legal  (legal)
  );

  vlc_len_calc #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_calc (
    .ra          (f.ra),
    .imm         (f.imm),
    .cnt_sel     (f.cnt_sel),
    .set_mvl     (f.set_mvl),
    .set_vl      (f.set_vl),
    .gpr_value   (gpr_value),
    .count_value (count_value),
    .vl_q        (vl_out),
    .mvl_q       (mvl_out),
    .vl_n        (vl_n),
    .mvl_n       (mvl_n)
  );

  assign exec = issue_valid && legal;

  vlc_state_reg #(.LEN_W(LEN_W)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (exec),
    .vl_n   (vl_n),
    .mvl_n  (mvl_n),
    .vf_n   (f.vfirst),
    .vl_q   (vl_out),
    .mvl_q  (mvl_out),
    .vf_q   (vfirst_out)
  );

  always_comb begin
    illegal    = issue_valid && !legal;
    wb_en      = exec && (f.rt != '0);
    wb_addr    = f.rt;
    wb_data    = DATA_W'(vl_n);
    zero_valid = exec && f.rec;
    zero_flag  = zero_valid && (vl_n == '0);
  end

  a_r5_state_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    vl_out <= mvl_out);
  a_r2_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(vl_out) && $stable(mvl_out) && $stable(vfirst_out));
  a_r2_illegal_no_side: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en && !zero_valid);
  a_r7_vf_written: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> vfirst_out == $past(instr[6]));
  a_r6_wb_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> DATA_W'(vl_out) == $past(wb_data));
  a_r8_zero_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag |-> zero_valid);
endmodule

// File: tb/sim_vl_config_unit.sv
module sim_vl_config_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [31:0] instr;
  logic [63:0] gpr_value, count_value;
  logic [6:0]  vl_out, mvl_out;
  logic        vfirst_out, wb_en, zero_valid, zero_flag, illegal;
  logic [4:0]  wb_addr;
  logic [63:0] wb_data;

  int checks = 0;
  int errors = 0;
  logic [6:0] m_vl, m_mvl;
  logic       m_vf;

  always #5 clk = ~clk;

  vl_config_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .gpr_value(gpr_value), .count_value(count_value),
    .vl_out(vl_out), .mvl_out(mvl_out), .vfirst_out(vfirst_out),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .zero_valid(zero_valid), .zero_flag(zero_flag), .illegal(illegal)
  );

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [6:0] sat(logic [63:0] v);
    return (v > 64'd127) ? 7'd127 : v[6:0];
  endfunction

  function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] rt, logic [4:0] ra,
      logic [5:0] imm, logic cv, logic ms, logic vs, logic vf, logic [4:0] xo, logic rc);
    return {po, rt, ra, imm, cv, ms, vs, vf, xo, rc};
  endfunction

  task automatic issue(string req, logic [31:0] w, logic [63:0] g, logic [63:0] c, logic v);
    logic       lg;
    logic [6:0] bimm, src, nmvl, nvl;
    lg   = (w[31:26] == 6'd22) && (w[5:1] == 5'b11110);
    bimm = 7'(w[15:10]) + 7'd1;
    nmvl = w[8] ? bimm : m_mvl;
    if (!w[7])                src = m_vl;
    else if (w[9])            src = sat(c);
    else if (w[20:16] != 5'd0) src = sat(g);
    else                      src = bimm;
    nvl = (src < nmvl) ? src : nmvl;
    @(negedge clk);
    issue_valid = v; instr = w; gpr_value = g; count_value = c;
    #1;
    check({req, " R2 illegal"}, illegal, v && !lg);
    check({req, " R6 wb_en"}, wb_en, v && lg && (w[25:21] != 0));
    if (v && lg && w[25:21] != 0) begin
      check({req, " R6 wb_addr"}, wb_addr, w[25:21]);
      check({req, " R6 wb_data"}, wb_data, 64'(nvl));
    end
    check({req, " R8 zero_valid"}, zero_valid, v && lg && w[0]);
    check({req, " R8 zero_flag"}, zero_flag, v && lg && w[0] && nvl == 0);
    if (v && lg) begin m_vl = nvl; m_mvl = nmvl; m_vf = w[6]; end
    @(posedge clk); #1;
    issue_valid = 1'b0;
    check({req, " R4/R5 vl"}, vl_out, m_vl);
    check({req, " R3 mvl"}, mvl_out, m_mvl);
    check({req, " R7 vf"}, vfirst_out, m_vf);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; issue_valid = 1'b0; instr = '0; gpr_value = '0; count_value = '0;
    m_vl = 0; m_mvl = 0; m_vf = 0;
    #23;
    check("R1 vl reset", vl_out, 0);
    check("R1 mvl reset", mvl_out, 0);
    check("R1 vf reset", vfirst_out, 0);
    @(negedge clk); rst_n = 1'b1;
    // R5: MVL is zero, so VL clamps to zero and the zero flag fires
    issue("R5 zero clamp", mk(22, 3, 4, 9, 0, 0, 1, 1, 30, 1), 64'd5, 64'd0, 1);
    // R3: set MVL to 8
    issue("R3 set mvl", mk(22, 0, 0, 7, 0, 1, 0, 0, 30, 1), 0, 0, 1);
    // R4: count outranks RA
    issue("R4 count prio", mk(22, 1, 7, 0, 1, 0, 1, 0, 30, 0), 64'd2, 64'd3, 1);
    issue("R5 count sat", mk(22, 1, 7, 0, 1, 0, 1, 0, 30, 0), 64'd2, 64'd1000, 1);
    issue("R4 gpr", mk(22, 2, 7, 0, 0, 0, 1, 1, 30, 0), 64'd5, 64'd99, 1);
    issue("R4 imm bias", mk(22, 2, 0, 0, 0, 0, 1, 0, 30, 1), 64'd5, 64'd99, 1);
    issue("R3 mvl 64", mk(22, 0, 0, 63, 0, 1, 0, 0, 30, 0), 0, 0, 1);
    issue("R5 gpr huge", mk(22, 9, 1, 0, 0, 0, 1, 0, 30, 0), 64'hFFFF_0000_0000_0001, 0, 1);
    // R5: shrink MVL under held VL with VL-enable clear
    issue("R5 shrink", mk(22, 4, 0, 3, 0, 1, 0, 1, 30, 0), 0, 0, 1);
    issue("R2 bad po", mk(21, 4, 0, 40, 0, 1, 1, 0, 30, 1), 0, 0, 1);
    issue("R2 bad xo", mk(22, 4, 0, 40, 0, 1, 1, 0, 29, 1), 0, 0, 1);
    issue("R9 idle", mk(22, 4, 0, 40, 0, 1, 1, 0, 30, 1), 0, 0, 0);
    issue("R8 zero gpr", mk(22, 5, 6, 0, 0, 0, 1, 0, 30, 1), 64'd0, 0, 1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [63:0] g, c;
      w = $urandom;
      if ($urandom_range(9) != 0) begin w[31:26] = 6'd22; w[5:1] = 5'b11110; end
      if ($urandom_range(3) == 0) w[20:16] = 5'd0;
      g = ($urandom_range(3) == 0) ? {$urandom, $urandom} : 64'($urandom_range(150));
      c = ($urandom_range(3) == 0) ? {$urandom, $urandom} : 64'($urandom_range(150));
      issue("rand R4", w, g, c, $urandom_range(7) != 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule